// File: doc/BRIEF.md
# Zigzag Search-Window Scan Controller

This block feeds the matching engine of an integer motion estimator. It keeps a window of reference pixels in registers and walks one group of sixteen candidate search points, four columns by four rows, in serpentine order. The window is three columns wider than the 16×16 block being matched. A move to a neighbouring column therefore only changes which sixteen of the nineteen columns are shown, and the block asks for new reference data only when the scan climbs one row.

Reference rows of nineteen 8-bit unsigned pixels arrive over a valid/ready handshake from the internal buffer. After a start pulse the block first takes sixteen rows to fill the window. It then presents one candidate at a time: the 16×16 reference block at the current column offset, the point index, and signed displacements. Each candidate is qualified by a valid strobe and held under downstream back-pressure. Each climb takes exactly one extra row, so a whole group uses nineteen rows and one fetch of cache data.

Top module: `zz_scan_ctrl`

## Requirements
- R1: After synchronous reset the block is idle: `row_ready`, `pt_valid` and `done` are low until a start pulse arrives.
- R2: After a start in idle, the block accepts exactly 16 rows with `row_ready` high and `pt_valid` low. `pt_valid` rises in the cycle after the 16th row is accepted.
- R3: Point index k (0..15) lies in point row r = k/4, counted upward from the bottom. Its position is p = k%4. Its column c is p when r is even and 3-p when r is odd. `pt_dx` = c and `pt_dy` = -r, both two's complement.
- R4: Every accepted row enters window row 0 and the older rows move one row down. The oldest row is dropped. Pixel j of `row_data` is bits [8j+7:8j]. Block pixel (y,x) sits at `pt_block` bits [8(16y+x)+7 : 8(16y+x)] and equals pixel x+c of window row y.
- R5: While a point is offered, `row_ready` stays low, so horizontal moves take no new row.
- R6: After the handshake of the 4th point of point rows 0 to 2, the block raises `row_ready` and shows no point. It stays there until one row is accepted, then offers the next point in the following cycle.
- R7: One group accepts exactly 19 rows from start to its final point.
- R8: While `pt_valid` is high and `pt_ready` is low, the index, displacements and block stay unchanged.
- R9: `done` is high for exactly the one cycle in which point 15 is handed over (`pt_valid` and `pt_ready` both high).
- R10: A start pulse during fill, stepping or point presentation has no effect on the scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new group when idle |
| row_valid | input | 1 | Reference row available |
| row_data | input | 152 | Nineteen 8-bit pixels, pixel j at bits [8j+7:8j] |
| row_ready | output | 1 | Block takes a row this cycle if valid |
| pt_valid | output | 1 | Candidate point offered |
| pt_ready | input | 1 | Downstream takes the candidate |
| pt_block | output | 2048 | 16×16 reference block, pixel (y,x) at 8(16y+x) |
| pt_idx | output | 4 | Index of the point in scan order |
| pt_dx | output | 3 | Signed column displacement |
| pt_dy | output | 3 | Signed row displacement |
| done | output | 1 | One-cycle pulse with the handover of the last point |

## Verification
The assertions assume the downstream side can stall for any number of cycles. They also assume `row_valid` may drop at will, and that `start` can arrive at any time, including mid-scan. They place no limit on how long a row or a handover takes. The stimulus covers three handshake regimes: always ready, coin-flip, and mostly stalled. Start pulses are injected inside fill and scan, and one reset lands in the middle of a group. Row contents are fresh random pixels every cycle, so the block contents show exactly which row was latched at each handshake.

// File: rtl/zz_pkg.sv
package zz_pkg;

  typedef enum logic [1:0] {
    ZZ_IDLE,
    ZZ_FILL,
    ZZ_SHOW,
    ZZ_STEP
  } zz_state_e;

  // point row counted from the bottom of the group
  function automatic int zz_prow(input int idx, input int pts);
    return idx / pts;
  endfunction

  // column offset: even point rows run left to right, odd rows right to left
  function automatic int zz_col(input int idx, input int pts);
    int pos;
    pos = idx % pts;
    if ((zz_prow(idx, pts) % 2) != 0) return pts - 1 - pos;
    return pos;
  endfunction

  function automatic int zz_dy(input int idx, input int pts);
    return -zz_prow(idx, pts);
  endfunction

  function automatic logic zz_row_end(input int idx, input int pts);
    return (idx % pts) == (pts - 1);
  endfunction

endpackage

// File: rtl/zz_window.sv
module zz_window #(
  parameter int PIX_W = 8,
  parameter int BLK   = 16,
  parameter int PTS   = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                shift_en,
  input  logic [(BLK+PTS-1)*PIX_W-1:0]        row_in,
  input  logic [$clog2(PTS)-1:0]              col_sel,
  output logic [BLK*BLK*PIX_W-1:0]            blk_out
);
  localparam int WIN_W  = BLK + PTS - 1;
  localparam int ROW_BW = WIN_W * PIX_W;

  logic [ROW_BW-1:0] rows_q [BLK];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < BLK; k++) rows_q[k] <= '0;
    end else if (shift_en) begin
      rows_q[0] <= row_in;
      for (int k = 1; k < BLK; k++) rows_q[k] <= rows_q[k-1];
    end
  end

  for (genvar y = 0; y < BLK; y++) begin : g_row
    for (genvar x = 0; x < BLK; x++) begin : g_pix
      assign blk_out[(y*BLK+x)*PIX_W +: PIX_W] =
        rows_q[y][(x + int'(col_sel)) * PIX_W +: PIX_W];
    end
  end

endmodule

// File: rtl/zz_seq.sv
module zz_seq
  import zz_pkg::*;
#(
  parameter int BLK = 16,
  parameter int PTS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         row_valid,
  input  logic                         pt_ready,
  output logic                         row_ready,
  output logic                         pt_valid,
  output logic [$clog2(PTS*PTS)-1:0]   idx,
  output logic                         row_take,
  output logic                         pt_take,
  output logic                         row_end,
  output logic                         last_pt
);
  localparam int NPTS  = PTS * PTS;
  localparam int IDX_W = $clog2(NPTS);
  localparam int CNT_W = $clog2(BLK + 1);

  zz_state_e        state;
  logic [CNT_W-1:0] fill_cnt;

  assign row_ready = (state == ZZ_FILL) || (state == ZZ_STEP);
  assign pt_valid  = (state == ZZ_SHOW);
  assign row_take  = row_valid && row_ready;
  assign pt_take   = pt_valid && pt_ready;
  assign row_end   = zz_row_end(int'(idx), PTS);
  assign last_pt   = (idx == IDX_W'(NPTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ZZ_IDLE;
      fill_cnt <= '0;
      idx      <= '0;
    end else begin
      case (state)
        ZZ_IDLE: if (start) begin
          state    <= ZZ_FILL;
          fill_cnt <= '0;
          idx      <= '0;
        end
        ZZ_FILL: if (row_take) begin
          fill_cnt <= fill_cnt + 1'b1;
          if (fill_cnt == CNT_W'(BLK - 1)) state <= ZZ_SHOW;
        end
        ZZ_SHOW: if (pt_take) begin
          if (last_pt)      state <= ZZ_IDLE;
          else if (row_end) state <= ZZ_STEP;
          else              idx   <= idx + 1'b1;
        end
        ZZ_STEP: if (row_take) begin
          idx   <= idx + 1'b1;
          state <= ZZ_SHOW;
        end
        default: state <= ZZ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/zz_scan_ctrl.sv
module zz_scan_ctrl
  import zz_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 16,
  parameter int PTS   = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  input  logic                                row_valid,
  input  logic [(BLK+PTS-1)*PIX_W-1:0]        row_data,
  output logic                                row_ready,
  output logic                                pt_valid,
  input  logic                                pt_ready,
  output logic [BLK*BLK*PIX_W-1:0]            pt_block,
  output logic [$clog2(PTS*PTS)-1:0]          pt_idx,
  output logic signed [$clog2(PTS):0]         pt_dx,
  output logic signed [$clog2(PTS):0]         pt_dy,
  output logic                                done
);
  localparam int COL_W = $clog2(PTS);
  localparam int D_W   = COL_W + 1;

  // internal events, visible to the bound checker
  logic             row_take;
  logic             pt_take;
  logic             row_end;
  logic             last_pt;
  logic             step_evt;
  logic [COL_W-1:0] col_sel;

  zz_seq #(.BLK(BLK), .PTS(PTS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .row_valid (row_valid),
    .pt_ready  (pt_ready),
    .row_ready (row_ready),
    .pt_valid  (pt_valid),
    .idx       (pt_idx),
    .row_take  (row_take),
    .pt_take   (pt_take),
    .row_end   (row_end),
    .last_pt   (last_pt)
  );

  assign col_sel  = COL_W'(zz_col(int'(pt_idx), PTS));
  assign pt_dx    = D_W'(zz_col(int'(pt_idx), PTS));
  assign pt_dy    = D_W'(zz_dy(int'(pt_idx), PTS));
  assign done     = pt_take && last_pt;
  assign step_evt = pt_take && row_end && !last_pt;

  zz_window #(.PIX_W(PIX_W), .BLK(BLK), .PTS(PTS)) u_win (
    .clk      (clk),
    .rst      (rst),
    .shift_en (row_take),
    .row_in   (row_data),
    .col_sel  (col_sel),
    .blk_out  (pt_block)
  );

endmodule

// File: rtl/zz_scan_chk.sv
module zz_scan_chk #(
  parameter int PTS = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         row_valid,
  input logic                         row_ready,
  input logic                         pt_valid,
  input logic                         pt_ready,
  input logic [$clog2(PTS*PTS)-1:0]   pt_idx,
  input logic                         done,
  input logic                         row_take,
  input logic                         pt_take,
  input logic                         step_evt
);
  localparam int NPTS  = PTS * PTS;
  localparam int IDX_W = $clog2(NPTS);

  a_r5_no_row_while_point: assert property (@(posedge clk) disable iff (rst)
    pt_valid |-> !row_ready);

  a_r2_no_point_on_load: assert property (@(posedge clk) disable iff (rst)
    row_take |-> !pt_valid);

  a_r6_step_asks_row: assert property (@(posedge clk) disable iff (rst)
    step_evt |=> row_ready && !pt_valid);

  a_r6_stall_until_row: assert property (@(posedge clk) disable iff (rst)
    (row_ready && !row_valid) |=> row_ready);

  a_r8_point_held: assert property (@(posedge clk) disable iff (rst)
    (pt_valid && !pt_ready) |=> pt_valid && $stable(pt_idx));

  a_r3_horizontal_next: assert property (@(posedge clk) disable iff (rst)
    (pt_take && !step_evt && !done) |=> pt_valid && (pt_idx == $past(pt_idx) + 1'b1));

  a_r9_done_on_last: assert property (@(posedge clk) disable iff (rst)
    done |-> pt_take && (pt_idx == IDX_W'(NPTS - 1)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind zz_scan_ctrl zz_scan_chk #(.PTS(PTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .row_valid (row_valid),
  .row_ready (row_ready),
  .pt_valid  (pt_valid),
  .pt_ready  (pt_ready),
  .pt_idx    (pt_idx),
  .done      (done),
  .row_take  (row_take),
  .pt_take   (pt_take),
  .step_evt  (step_evt)
);

// File: tb/test_zz_scan_ctrl.sv
`timescale 1ns/1ps
module test_zz_scan_ctrl;
  localparam int ROW_BITS = 19 * 8;
  localparam int BLK_BITS = 16 * 16 * 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start = 1'b0;
  logic                 row_valid = 1'b0;
  logic [ROW_BITS-1:0]  row_data = '0;
  logic                 row_ready;
  logic                 pt_valid;
  logic                 pt_ready = 1'b0;
  logic [BLK_BITS-1:0]  pt_block;
  logic [3:0]           pt_idx;
  logic signed [2:0]    pt_dx;
  logic signed [2:0]    pt_dy;
  logic                 done;

  zz_scan_ctrl i_zz_scan_ctrl (
    .clk(clk), .rst(rst), .start(start), .row_valid(row_valid),
    .row_data(row_data), .row_ready(row_ready), .pt_valid(pt_valid),
    .pt_ready(pt_ready), .pt_block(pt_block), .pt_idx(pt_idx),
    .pt_dx(pt_dx), .pt_dy(pt_dy), .done(done)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit wd_hit = 1'b0;
  int mode = 0;

  // behavioural model state
  int m_state = 0;              // 0 idle, 1 loading, 2 offering, 3 climbing
  int m_cnt = 0;
  int m_idx = 0;
  int m_groups = 0;
  int m_rows = 0;
  logic [ROW_BITS-1:0] m_win[$];
  int col_tab[16] = '{0,1,2,3, 3,2,1,0, 0,1,2,3, 3,2,1,0};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [BLK_BITS-1:0] exp_block(input int c);
    logic [BLK_BITS-1:0] b;
    b = '0;
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++)
        b[(y*16+x)*8 +: 8] = m_win[y][(x+c)*8 +: 8];
    return b;
  endfunction

  // input driver: 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    for (int j = 0; j < 19; j++) row_data[j*8 +: 8] = 8'($urandom);
    case (mode)
      0: begin row_valid = 1'b1; pt_ready = 1'b1; end
      1: begin row_valid = 1'($urandom); pt_ready = 1'($urandom); end
      default: begin
        row_valid = ($urandom % 4) == 0;
        pt_ready  = ($urandom % 4) == 0;
      end
    endcase
  end

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    cycles++;
    if (row_valid && row_ready) m_rows++;
    if (rst) begin
      m_state = 0; m_cnt = 0; m_idx = 0;
      m_win.delete();
    end else begin
      case (m_state)
        0: if (start) begin m_state = 1; m_cnt = 0; m_idx = 0; m_rows = 0; end
        1: if (row_valid) begin
          m_win.push_front(row_data);
          if (m_win.size() > 16) void'(m_win.pop_back());
          m_cnt++;
          if (m_cnt == 16) m_state = 2;
        end
        2: if (pt_ready) begin
          if (m_idx == 15) begin
            m_state = 0;
            m_groups++;
            check(m_rows == 19, "R7", "rows per group", m_rows, 19);
          end else if (m_idx % 4 == 3) m_state = 3;
          else m_idx++;
        end
        default: if (row_valid) begin
          m_win.push_front(row_data);
          if (m_win.size() > 16) void'(m_win.pop_back());
          m_idx++;
          m_state = 2;
        end
      endcase
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      bit e_rr, e_pv, e_dn;
      e_rr = (m_state == 1) || (m_state == 3);
      e_pv = (m_state == 2);
      e_dn = e_pv && (m_idx == 15) && pt_ready;
      check(row_ready == e_rr, "R5/R6/R10", "row_ready", row_ready, e_rr);
      check(pt_valid == e_pv, "R2/R10", "pt_valid", pt_valid, e_pv);
      check(done == e_dn, "R9", "done", done, e_dn);
      if (e_pv && pt_valid) begin
        check(pt_idx == 4'(m_idx), "R3/R8", "pt_idx", pt_idx, m_idx);
        check(int'(pt_dx) == col_tab[m_idx], "R3", "pt_dx", pt_dx, col_tab[m_idx]);
        check(int'(pt_dy) == -(m_idx / 4), "R3", "pt_dy", pt_dy, -(m_idx / 4));
        check(pt_block == exp_block(col_tab[m_idx]), "R4/R8", "pt_block mismatch at idx",
              m_idx, m_idx);
      end
    end
  end

  task automatic run_group(input int md, input bit noise);
    int g0, n;
    mode = md;
    g0 = m_groups;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    n = 0;
    while (m_groups == g0 && !wd_hit) begin
      @(posedge clk); #1;
      n++;
      start = noise && (n == 10 || n == 25);   // R10: ignored start pulses
    end
    start = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    check(!row_ready, tag, "row_ready idle", row_ready, 0);
    check(!pt_valid, tag, "pt_valid idle", pt_valid, 0);
    check(!done, tag, "done idle", done, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check_idle("R1");
    run_group(0, 1'b0);
    run_group(1, 1'b1);
    run_group(2, 1'b1);
    // reset in the middle of a group, R1
    mode = 1;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (40) @(posedge clk);
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    check_idle("R1");
    run_group(1, 1'b0);
    run_group(0, 1'b1);
    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    wd_hit = 1'b1;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule